// File: doc/BRIEF.md
# Frequency Synthesizer Coefficient Register Port

This block holds the divider coefficients of a synthesizer that drives two output clocks. A host reaches it through three byte-wide port addresses. Two of them set independent pointers: one for writing and one for reading. The third is a shared data port. Each pointer index names a coefficient slot of two bytes. The multiplier byte M comes first. The second byte packs the post-divider P in bits 6:5 and the pre-divider N in bits 4:0. Consecutive data accesses move through the two bytes of a slot and then on to the next slot. Each direction keeps its own pointer and its own byte phase.

One pointer index, `CTRL_IDX` (default 14), is not a slot. It is a single-byte control register that picks the slot feeding each clock. Bits 2:0 name the slot (0 to 7) used by clock 0. Bit 4 picks slot 0xA (when 1) or slot 0xB (when 0) for clock 1. The decoded M, P and N of both chosen slots appear on output ports at all times.

Reset loads every slot from parameters. This lets a host identify the device by reading the M bytes of slots 1, 7 and 0xB. With the default parameters these read 0x19, 0x5B and 0x4A. Every other M byte is 0x20, and every P/N byte is 0x45.

Top module: `pll_coef_regport`

## Requirements
- R1: Host address 0 loads the write pointer and host address 2 loads the read pointer, each from `host_wdata[PTR_W-1:0]`. Loading one pointer leaves the other unchanged. A read of address 0 or 2 returns that pointer, zero-extended.
- R2: After a pointer load, the first data-port access (address 1) in that direction transfers the slot's M byte. The second transfers its P/N byte.
- R3: The second byte of a slot moves the pointer to the next index, wrapping modulo 2^PTR_W, and returns the phase to M.
- R4: Loading a pointer returns that direction's byte phase to M, even in the middle of a slot.
- R5: After reset, each slot holds its M and P/N bytes from `M_INIT` and `PN_INIT`. Defaults: slot 1 M=0x19, slot 7 M=0x5B, slot 0xB M=0x4A, other M=0x20, every P/N=0x45. The control register resets to `CTRL_INIT` (default 0x00).
- R6: A data access at index `CTRL_IDX` reads or writes the whole control byte. It does not move the pointer or the phase.
- R7: Clock 0 outputs come from slot `ctrl[2:0]`: M = M byte bits 6:0, P = P/N bits 6:5, N = P/N bits 4:0.
- R8: Clock 1 outputs come from slot 0xA when `ctrl[4]`=1 and from slot 0xB when it is 0. A write to the selected slot shows on the outputs right after the write edge.
- R9: Read data appears on `host_rdata` one clock after the request and holds until the next read. Address 3 reads as 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 write pointer, 1 data, 2 read pointer, 3 unused |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| clk0_m | output | 7 | Clock 0 multiplier |
| clk0_p | output | 2 | Clock 0 post-divider code |
| clk0_n | output | 5 | Clock 0 pre-divider |
| clk1_m | output | 7 | Clock 1 multiplier |
| clk1_p | output | 2 | Clock 1 post-divider code |
| clk1_n | output | 5 | Clock 1 pre-divider |

## Verification
The bench builds the block with its default parameters: a 4-bit pointer, 16 indices and the control register at 14. This small space lets it walk every slot in both directions, including the stall at the control index and the wrap from 15 to 0. Expected bytes come from a per-slot arithmetic pattern held in a bench model. It sweeps all eight clock-0 selections and both clock-1 selections through masked control updates. It also covers mid-slot pointer reloads and the unused address.

// File: rtl/pll_coef_pkg.sv
package pll_coef_pkg;
   typedef enum logic [1:0] {
      HA_WPTR = 2'd0,
      HA_DATA = 2'd1,
      HA_RPTR = 2'd2,
      HA_NONE = 2'd3
   } host_addr_e;

   typedef enum logic {
      PH_M  = 1'b0,
      PH_PN = 1'b1
   } byte_phase_e;
endpackage

// File: rtl/pll_coef_ptr.sv
module pll_coef_ptr
   import pll_coef_pkg::*;
#(
   parameter int PTR_W    = 4,
   parameter int CTRL_IDX = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             step,
   output logic [PTR_W-1:0] ptr,
   output byte_phase_e      phase
);
   localparam logic [PTR_W-1:0] CTRL_P = PTR_W'(CTRL_IDX);

   logic at_ctrl;
   assign at_ctrl = (ptr == CTRL_P);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         phase <= PH_M;
      end else if (load) begin
         ptr   <= load_val;
         phase <= PH_M;
      end else if (step && !at_ctrl) begin
         if (phase == PH_M) begin
            phase <= PH_PN;
         end else begin
            phase <= PH_M;
            ptr   <= ptr + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pll_coef_store.sv
module pll_coef_store
   import pll_coef_pkg::*;
#(
   parameter int PTR_W     = 4,
   parameter int CTRL_IDX  = 14,
   parameter logic [8*(2**PTR_W)-1:0] M_INIT  = '0,
   parameter logic [8*(2**PTR_W)-1:0] PN_INIT = '0,
   parameter logic [7:0] CTRL_INIT = 8'h00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [PTR_W-1:0]        wr_idx,
   input  byte_phase_e             wr_phase,
   input  logic [7:0]              wr_data,
   input  logic [PTR_W-1:0]        rd_idx,
   input  byte_phase_e             rd_phase,
   output logic [7:0]              rd_byte,
   output logic [8*(2**PTR_W)-1:0] m_flat,
   output logic [8*(2**PTR_W)-1:0] pn_flat,
   output logic [7:0]              ctrl
);
   localparam int NSLOT = 2**PTR_W;
   localparam logic [PTR_W-1:0] CTRL_P = PTR_W'(CTRL_IDX);

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i == CTRL_IDX) begin : g_hole
         assign m_flat[8*i +: 8]  = 8'h00;
         assign pn_flat[8*i +: 8] = 8'h00;
      end else begin : g_reg
         logic [7:0] m_r, pn_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               m_r  <= M_INIT[8*i +: 8];
               pn_r <= PN_INIT[8*i +: 8];
            end else if (wr_en && wr_idx == PTR_W'(i)) begin
               if (wr_phase == PH_M) m_r  <= wr_data;
               else                  pn_r <= wr_data;
            end
         end
         assign m_flat[8*i +: 8]  = m_r;
         assign pn_flat[8*i +: 8] = pn_r;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl <= CTRL_INIT;
      else if (wr_en && wr_idx == CTRL_P)  ctrl <= wr_data;
   end

   always_comb begin
      if (rd_idx == CTRL_P)        rd_byte = ctrl;
      else if (rd_phase == PH_PN)  rd_byte = pn_flat[{rd_idx, 3'b000} +: 8];
      else                         rd_byte = m_flat[{rd_idx, 3'b000} +: 8];
   end
endmodule

// File: rtl/pll_coef_sel.sv
module pll_coef_sel #(
   parameter int PTR_W  = 4,
   parameter int CLK1_A = 10,
   parameter int CLK1_B = 11
) (
   input  logic [8*(2**PTR_W)-1:0] m_flat,
   input  logic [8*(2**PTR_W)-1:0] pn_flat,
   input  logic [2:0]              clk0_slot,
   input  logic                    clk1_alt,
   output logic [6:0]              clk0_m,
   output logic [1:0]              clk0_p,
   output logic [4:0]              clk0_n,
   output logic [6:0]              clk1_m,
   output logic [1:0]              clk1_p,
   output logic [4:0]              clk1_n
);
   logic [PTR_W-1:0] idx0, idx1;
   logic [7:0] m0, pn0, m1, pn1;

   assign idx0 = PTR_W'(clk0_slot);
   assign idx1 = clk1_alt ? PTR_W'(CLK1_A) : PTR_W'(CLK1_B);

   assign m0  = m_flat[{idx0, 3'b000} +: 8];
   assign pn0 = pn_flat[{idx0, 3'b000} +: 8];
   assign m1  = m_flat[{idx1, 3'b000} +: 8];
   assign pn1 = pn_flat[{idx1, 3'b000} +: 8];

   assign clk0_m = m0[6:0];
   assign clk0_p = pn0[6:5];
   assign clk0_n = pn0[4:0];
   assign clk1_m = m1[6:0];
   assign clk1_p = pn1[6:5];
   assign clk1_n = pn1[4:0];
endmodule

// File: rtl/pll_coef_regport.sv
module pll_coef_regport
   import pll_coef_pkg::*;
#(
   parameter int PTR_W    = 4,
   parameter int CTRL_IDX = 14,
   parameter logic [8*(2**PTR_W)-1:0] M_INIT =
      128'h20_20_20_20_4A_20_20_20_5B_20_20_20_20_20_19_20,
   parameter logic [8*(2**PTR_W)-1:0] PN_INIT = {(2**PTR_W){8'h45}},
   parameter logic [7:0] CTRL_INIT = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_sel,
   input  logic       host_we,
   input  logic [1:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic [6:0] clk0_m,
   output logic [1:0] clk0_p,
   output logic [4:0] clk0_n,
   output logic [6:0] clk1_m,
   output logic [1:0] clk1_p,
   output logic [4:0] clk1_n
);
   localparam int NSLOT = 2**PTR_W;

   if (PTR_W < 4 || PTR_W > 8) begin : g_bad_w
      $error("PTR_W must be 4..8");
   end
   if (CTRL_IDX >= NSLOT || CTRL_IDX == 0 || CTRL_IDX == 1 || CTRL_IDX == 7 ||
       CTRL_IDX == 10 || CTRL_IDX == 11) begin : g_bad_ctrl
      $error("CTRL_IDX collides with a fixed slot or is out of range");
   end

   host_addr_e  addr_e;
   logic        wr_acc, rd_acc;
   logic [PTR_W-1:0] wptr_q, rptr_q;
   byte_phase_e wphase_q, rphase_q;
   logic [7:0]  rd_byte, ctrl_q;
   logic [8*NSLOT-1:0] m_flat, pn_flat;

   assign addr_e = host_addr_e'(host_addr);
   assign wr_acc = host_sel &&  host_we;
   assign rd_acc = host_sel && !host_we;

   pll_coef_ptr #(.PTR_W(PTR_W), .CTRL_IDX(CTRL_IDX)) u_wptr (
      .clk(clk), .rst_n(rst_n),
      .load(wr_acc && addr_e == HA_WPTR),
      .load_val(host_wdata[PTR_W-1:0]),
      .step(wr_acc && addr_e == HA_DATA),
      .ptr(wptr_q), .phase(wphase_q));

   pll_coef_ptr #(.PTR_W(PTR_W), .CTRL_IDX(CTRL_IDX)) u_rptr (
      .clk(clk), .rst_n(rst_n),
      .load(wr_acc && addr_e == HA_RPTR),
      .load_val(host_wdata[PTR_W-1:0]),
      .step(rd_acc && addr_e == HA_DATA),
      .ptr(rptr_q), .phase(rphase_q));

   pll_coef_store #(
      .PTR_W(PTR_W), .CTRL_IDX(CTRL_IDX),
      .M_INIT(M_INIT), .PN_INIT(PN_INIT), .CTRL_INIT(CTRL_INIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_acc && addr_e == HA_DATA),
      .wr_idx(wptr_q), .wr_phase(wphase_q), .wr_data(host_wdata),
      .rd_idx(rptr_q), .rd_phase(rphase_q), .rd_byte(rd_byte),
      .m_flat(m_flat), .pn_flat(pn_flat), .ctrl(ctrl_q));

   pll_coef_sel #(.PTR_W(PTR_W), .CLK1_A(10), .CLK1_B(11)) u_sel (
      .m_flat(m_flat), .pn_flat(pn_flat),
      .clk0_slot(ctrl_q[2:0]), .clk1_alt(ctrl_q[4]),
      .clk0_m(clk0_m), .clk0_p(clk0_p), .clk0_n(clk0_n),
      .clk1_m(clk1_m), .clk1_p(clk1_p), .clk1_n(clk1_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= 8'h00;
      end else if (rd_acc) begin
         case (addr_e)
            HA_WPTR: host_rdata <= 8'(wptr_q);
            HA_RPTR: host_rdata <= 8'(rptr_q);
            HA_DATA: host_rdata <= rd_byte;
            default: host_rdata <= 8'h00;
         endcase
      end
   end
endmodule

// File: rtl/pll_coef_chk.sv
module pll_coef_chk #(
   parameter int PTR_W    = 4,
   parameter int CTRL_IDX = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_sel,
   input logic             host_we,
   input logic [1:0]       host_addr,
   input logic [7:0]       host_wdata,
   input logic [PTR_W-1:0] wptr,
   input logic             wphase,
   input logic [PTR_W-1:0] rptr,
   input logic             rphase,
   input logic             clk1_alt,
   input logic [4:0]       clk1_n
);
   localparam logic [PTR_W-1:0] CTRL_P = PTR_W'(CTRL_IDX);

   logic wdat;
   assign wdat = host_sel && host_we && host_addr == 2'd1;

   AST_WPTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_we && host_addr == 2'd0) |=>
      (wptr == $past(host_wdata[PTR_W-1:0]) && !wphase && $stable(rptr))); // R1

   AST_RPTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_we && host_addr == 2'd2) |=>
      (rptr == $past(host_wdata[PTR_W-1:0]) && !rphase)); // R4

   AST_M_THEN_PN: assert property (@(posedge clk) disable iff (!rst_n)
      (wdat && wptr != CTRL_P && !wphase) |=> (wphase && $stable(wptr))); // R2

   AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wdat && wptr != CTRL_P && wphase) |=>
      (!wphase && wptr == PTR_W'($past(wptr) + 1'b1))); // R3

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wdat && wptr == CTRL_P) |=> ($stable(wptr) && $stable(wphase))); // R6

   AST_CLK1_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wdat && wptr == PTR_W'(10) && wphase && clk1_alt) |=>
      (clk1_n == $past(host_wdata[4:0]))); // R8
endmodule

bind pll_coef_regport pll_coef_chk #(.PTR_W(PTR_W), .CTRL_IDX(CTRL_IDX)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
   .host_addr(host_addr), .host_wdata(host_wdata),
   .wptr(wptr_q), .wphase(wphase_q), .rptr(rptr_q), .rphase(rphase_q),
   .clk1_alt(ctrl_q[4]), .clk1_n(clk1_n));

// File: tb/sim_pll_coef_regport.sv
`timescale 1ns/1ps
module sim_pll_coef_regport;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, we = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [6:0] c0m, c1m;
   logic [1:0] c0p, c1p;
   logic [4:0] c0n, c1n;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [7:0] em [16];
   logic [7:0] epn [16];
   logic [7:0] ectrl;
   logic [7:0] rv;

   localparam logic [1:0] A_WP = 2'd0, A_DT = 2'd1, A_RP = 2'd2, A_NO = 2'd3;
   localparam int CIDX = 14;

   always #10 clk = ~clk;

   pll_coef_regport u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_we(we),
      .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
      .clk0_m(c0m), .clk0_p(c0p), .clk0_n(c0n),
      .clk1_m(c1m), .clk1_p(c1p), .clk1_n(c1n));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hw(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); sel = 1'b0; we = 1'b0;
   endtask

   task automatic hr(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
      @(negedge clk); sel = 1'b0; d = rdata;
   endtask

   task automatic chk_clk0(input string tag, input int s);
      chk({tag, " m0"}, 32'(c0m), 32'(em[s][6:0]));
      chk({tag, " p0"}, 32'(c0p), 32'(epn[s][6:5]));
      chk({tag, " n0"}, 32'(c0n), 32'(epn[s][4:0]));
   endtask

   task automatic chk_clk1(input string tag, input int s);
      chk({tag, " m1"}, 32'(c1m), 32'(em[s][6:0]));
      chk({tag, " p1"}, 32'(c1p), 32'(epn[s][6:5]));
      chk({tag, " n1"}, 32'(c1n), 32'(epn[s][4:0]));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         em[i] = 8'h20; epn[i] = 8'h45;
      end
      em[1] = 8'h19; em[7] = 8'h5B; em[11] = 8'h4A;
      ectrl = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 R7 R8 reset state
      chk("R5 rdata reset", 32'(rdata), 0);
      chk_clk0("R7 reset", 0);
      chk_clk1("R8 reset slot B", 11);

      // R5 R2 identification slots
      foreach (em[s]) if (s == 1 || s == 7 || s == 11) begin
         hw(A_RP, 8'(s));
         hr(A_DT, rv); chk("R5 ident M", 32'(rv), 32'(em[s]));
         hr(A_DT, rv); chk("R2 ident PN", 32'(rv), 32'(epn[s]));
      end

      // R1 independent pointers
      hw(A_WP, 8'd5);
      hr(A_WP, rv); chk("R1 wptr readback", 32'(rv), 5);
      hr(A_RP, rv); chk("R1 rptr untouched", 32'(rv), 12);

      // R2 R3 walking writes across slots 0..13
      hw(A_WP, 8'd0);
      for (int i = 0; i < CIDX; i++) begin
         em[i]  = 8'((i * 9 + 3) % 127 + 1);
         epn[i] = {1'b0, 2'(i % 4), 5'(i % 31 + 1)};
         hw(A_DT, em[i]);
         hw(A_DT, epn[i]);
      end
      hr(A_WP, rv); chk("R3 wptr reaches ctrl index", 32'(rv), CIDX);
      em[15] = 8'h7F; epn[15] = 8'h7F;
      hw(A_WP, 8'd15); hw(A_DT, em[15]); hw(A_DT, epn[15]);
      hr(A_WP, rv); chk("R3 wptr wraps", 32'(rv), 0);

      // R2 R3 walking reads
      hw(A_RP, 8'd0);
      for (int i = 0; i < CIDX; i++) begin
         hr(A_DT, rv); chk("R2 read M", 32'(rv), 32'(em[i]));
         hr(A_DT, rv); chk("R2 read PN", 32'(rv), 32'(epn[i]));
      end
      hr(A_RP, rv); chk("R3 rptr at ctrl", 32'(rv), CIDX);
      // R6 control index holds the pointer
      hr(A_DT, rv); chk("R6 ctrl read 1", 32'(rv), 32'(ectrl));
      hr(A_DT, rv); chk("R6 ctrl read 2", 32'(rv), 32'(ectrl));
      hr(A_RP, rv); chk("R6 rptr stays", 32'(rv), CIDX);
      hw(A_RP, 8'd15);
      hr(A_DT, rv); chk("R2 slot15 M", 32'(rv), 32'(em[15]));
      hr(A_DT, rv); chk("R2 slot15 PN", 32'(rv), 32'(epn[15]));
      hr(A_RP, rv); chk("R3 rptr wraps", 32'(rv), 0);

      // R4 mid-slot pointer reload
      hw(A_WP, 8'd3); hw(A_DT, 8'h11);
      hw(A_WP, 8'd3); hw(A_DT, 8'h22); hw(A_DT, 8'h33);
      em[3] = 8'h22; epn[3] = 8'h33;
      hw(A_RP, 8'd3); hr(A_DT, rv); chk("R4 write phase reset M", 32'(rv), 32'(em[3]));
      hw(A_RP, 8'd3); hr(A_DT, rv); chk("R4 read phase reset M", 32'(rv), 32'(em[3]));
      hr(A_DT, rv); chk("R4 PN after reload", 32'(rv), 32'(epn[3]));

      // R7 clock 0 sweep through masked control updates
      for (int c = 0; c < 8; c++) begin
         ectrl = (ectrl & 8'hD8) | 8'(c) | 8'hC8;
         hw(A_WP, 8'(CIDX)); hw(A_DT, ectrl);
         chk_clk0("R7 sweep", c);
         chk_clk1("R8 unaffected", 11);
      end
      hw(A_RP, 8'(CIDX)); hr(A_DT, rv); chk("R6 ctrl readback", 32'(rv), 32'(ectrl));

      // R8 clock 1 selection
      ectrl = (ectrl & 8'hEF) | 8'h10;
      hw(A_WP, 8'(CIDX)); hw(A_DT, ectrl);
      chk_clk1("R8 slot A", 10);
      chk_clk0("R7 held", 7);
      hw(A_WP, 8'd10); hw(A_DT, 8'h05); hw(A_DT, 8'h3C);
      em[10] = 8'h05; epn[10] = 8'h3C;
      chk_clk1("R8 live update", 10);
      ectrl = ectrl & 8'hEF;
      hw(A_WP, 8'(CIDX)); hw(A_DT, ectrl);
      chk_clk1("R8 slot B", 11);

      // R9 unused address and read-data hold
      hw(A_WP, 8'd6);
      hw(A_NO, 8'hFF);
      hr(A_WP, rv); chk("R9 write to addr3 ignored wptr", 32'(rv), 6);
      hr(A_RP, rv); chk("R9 write to addr3 ignored rptr", 32'(rv), 32'(CIDX));
      hr(A_DT, rv); chk("R9 ctrl intact", 32'(rv), 32'(ectrl));
      hr(A_NO, rv); chk("R9 addr3 reads zero", 32'(rv), 0);
      hw(A_RP, 8'd9);
      repeat (2) @(negedge clk);
      chk("R9 rdata holds", 32'(rdata), 0);
      hr(A_DT, rv); chk("R9 one-cycle read", 32'(rv), 32'(em[9]));

      finish_run();
   end
endmodule